// File: doc/BRIEF.md
# Packed-Lane Integer Multiply Unit

This unit decodes a 32-bit vector multiply instruction word and multiplies packed integer lanes of two 128-bit operands. From the instruction it takes the lane width (8, 16 or 32 bits), the active vector width (low 64 bits or all 128), the form, and the register indices. The two source register indices leave the unit combinationally in the same cycle, so an external register file can return both operands in that cycle alongside the instruction.

Two forms are recognised. In the lane-pair form, lane i of the first operand is multiplied by lane i of the second. In the broadcast form, every lane of the first operand is multiplied by one indexed lane of the second. Each product keeps only its low lane-width bits. A lane-pair word with bit 29 set selects carry-less multiplication of 8-bit lanes. Words that are reserved or not recognised raise an undefined flag and never write. The unit is a two-stage pipeline that accepts one instruction per cycle and has no condition-flag side effects.

Top module: `simd_lane_mul`

## Requirements
- R1: A word presented with `inValid` high produces `outValid` high exactly two cycles later. `outValid` is low two cycles after a cycle with `inValid` low. A new word is accepted every cycle.
- R2: The lane-pair form is the pattern bit31=0, bits28:24=01110, bit21=1, bits15:11=10011, bit10=1. Bits 23:22 give the lane size: 00 for 8-bit, 01 for 16-bit, 10 for 32-bit. Result lane i is (A lane i × B lane i) mod 2^lanewidth.
- R3: Bit 30 = 0 makes only the low 64 bits active, and result bits 127:64 are zero. Bit 30 = 1 makes all 128 bits active.
- R4: The broadcast form is the pattern bit31=0, bit29=0, bits28:24=01111, bits15:12=1000, bit10=0. With size 01 (16-bit), the lane index is {bit11, bit21, bit20} (0..7) and `idxM` is {0, bits19:16}.
- R5: In the broadcast form with size 10 (32-bit), the lane index is {bit11, bit21} (0..3) and `idxM` is bits 20:16.
- R6: In the lane-pair form, bit 29 = 1 with size 00 makes each 8-bit result lane the carry-less (XOR-accumulated) product of the two lanes, truncated to 8 bits. For example, 0x03 and 0x03 give 0x05.
- R7: The following words are undefined: size 11 in either form, size 00 in the broadcast form, bit 29 = 1 with a size other than 00 in the lane-pair form, and any word matching neither pattern. For such a word, two cycles later `outValid`=1, `undef`=1, `wrEn`=0 and `result`=0.
- R8: `idxN` is bits 9:5 and, except as R4 states, `idxM` is bits 20:16, both combinational from `instr`. `dstIdx` carries bits 4:0 two cycles later. `wrEn` is high only with `outValid` and a defined word.
- R9: While reset is applied and right after it, `outValid`, `wrEn` and `undef` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| srcA | input | 128 | Operand read from register idxN |
| srcB | input | 128 | Operand read from register idxM |
| idxN | output | 5 | First source register index (combinational) |
| idxM | output | 5 | Second source register index (combinational) |
| outValid | output | 1 | Result slot valid |
| wrEn | output | 1 | Write the result to dstIdx |
| undef | output | 1 | Instruction word was undefined |
| dstIdx | output | 5 | Destination register index |
| result | output | 128 | Packed product lanes |

## Verification
On every cycle the assertions check the following: the fixed two-cycle relation between `inValid` and `outValid`, that the destination index arrives with that delay, that a write never coincides with an undefined or empty slot, that size 11 always becomes undefined, and that the upper half is zero for 64-bit operation. Only the bench scenarios can show the product values. These include wraparound on all-ones lanes, the carry-less results, which lane the broadcast form selects for every index value, and the remapping of the second register field for 16-bit broadcast. A seeded random stream of mixed forms, sizes and garbage words, sent back to back, also checks undefined decoding against an independent model.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_IDX_W = 5;
  localparam int VEC_W = 128;
  localparam int SLICE_W = 32;
  localparam int NSLICE = VEC_W / SLICE_W;
  localparam int HALF_W = VEC_W / 2;

  typedef enum logic [1:0] {
    LANE8  = 2'b00,
    LANE16 = 2'b01,
    LANE32 = 2'b10
  } laneSz_e;

  typedef struct packed {
    logic    live;
    laneSz_e laneSz;
    logic    wide;
    logic    poly;
    logic    byElem;
    logic [2:0] elemIdx;
  } dpStrobe_t;
endpackage

// File: rtl/simd_mul_ctrl.sv
module simd_mul_ctrl
  import simd_mul_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic [INSTR_W-1:0]   instr,
  output logic [REG_IDX_W-1:0] idxN,
  output logic [REG_IDX_W-1:0] idxM,
  output dpStrobe_t            stb,
  output logic                 outValid,
  output logic                 wrEn,
  output logic                 undef,
  output logic [REG_IDX_W-1:0] dstIdx
);
  logic [1:0] sz;
  logic isVec, isElem, polyReq, legal;
  logic [2:0] elemIdx;
  logic s1Valid, s1Undef;
  logic [REG_IDX_W-1:0] s1Dst;

  always_comb begin
    sz      = instr[23:22];
    polyReq = instr[29];
    isVec   = !instr[31] && (instr[28:24] == 5'b01110) && instr[21] &&
              (instr[15:11] == 5'b10011) && instr[10];
    isElem  = !instr[31] && !instr[29] && (instr[28:24] == 5'b01111) &&
              (instr[15:12] == 4'b1000) && !instr[10];
    legal   = (isVec && (polyReq ? (sz == 2'b00) : (sz != 2'b11))) ||
              (isElem && ((sz == 2'b01) || (sz == 2'b10)));
    elemIdx = (sz == 2'b01) ? {instr[11], instr[21], instr[20]}
                            : {1'b0, instr[11], instr[21]};
    idxN    = instr[9:5];
    idxM    = (isElem && (sz == 2'b01)) ? {1'b0, instr[19:16]} : instr[20:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb      <= '0;
      s1Valid  <= 1'b0;
      s1Undef  <= 1'b0;
      s1Dst    <= '0;
      outValid <= 1'b0;
      wrEn     <= 1'b0;
      undef    <= 1'b0;
      dstIdx   <= '0;
    end else begin
      stb.live    <= inValid && legal;
      stb.laneSz  <= laneSz_e'(sz);
      stb.wide    <= instr[30];
      stb.poly    <= isVec && polyReq;
      stb.byElem  <= isElem;
      stb.elemIdx <= elemIdx;
      s1Valid     <= inValid;
      s1Undef     <= inValid && !legal;
      s1Dst       <= instr[4:0];
      outValid    <= s1Valid;
      wrEn        <= stb.live;
      undef       <= s1Undef;
      dstIdx      <= s1Dst;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> ##2 outValid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |-> ##2 !outValid);
  p_reserved_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && instr[23:22] == 2'b11) |-> ##2 (outValid && undef && !wrEn));
  p_write_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> (outValid && !undef));
  p_dst_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> ##2 (dstIdx == $past(instr[4:0], 2)));
endmodule

// File: rtl/simd_mul_dp.sv
module simd_mul_dp
  import simd_mul_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opLoad,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  dpStrobe_t        stb,
  output logic [VEC_W-1:0] result
);
  logic [VEC_W-1:0] a1, b1, bEff, prodAll, prodMasked;
  logic [15:0] bLane16;
  logic [31:0] bLane32;

  function automatic logic [7:0] clmul8(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) acc = acc ^ (16'(x) << i);
    end
    return acc[7:0];
  endfunction

  function automatic logic [SLICE_W-1:0] sliceMul(input logic [SLICE_W-1:0] x,
                                                  input logic [SLICE_W-1:0] y,
                                                  input laneSz_e sz,
                                                  input logic poly);
    logic [SLICE_W-1:0] r;
    logic [7:0] p8;
    logic [15:0] p16;
    r = '0;
    case (sz)
      LANE8: begin
        for (int k = 0; k < SLICE_W / 8; k++) begin
          p8 = x[8*k +: 8] * y[8*k +: 8];
          r[8*k +: 8] = poly ? clmul8(x[8*k +: 8], y[8*k +: 8]) : p8;
        end
      end
      LANE16: begin
        for (int k = 0; k < SLICE_W / 16; k++) begin
          p16 = x[16*k +: 16] * y[16*k +: 16];
          r[16*k +: 16] = p16;
        end
      end
      default: r = x * y;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1 <= '0;
      b1 <= '0;
    end else if (opLoad) begin
      a1 <= srcA;
      b1 <= srcB;
    end
  end

  always_comb begin
    bLane16 = b1[{stb.elemIdx, 4'b0000} +: 16];
    bLane32 = b1[{stb.elemIdx[1:0], 5'b00000} +: 32];
    if (!stb.byElem)
      bEff = b1;
    else if (stb.laneSz == LANE16)
      bEff = {(VEC_W / 16){bLane16}};
    else
      bEff = {(VEC_W / 32){bLane32}};
  end

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    assign prodAll[g*SLICE_W +: SLICE_W] =
      sliceMul(a1[g*SLICE_W +: SLICE_W], bEff[g*SLICE_W +: SLICE_W], stb.laneSz, stb.poly);
  end

  always_comb begin
    prodMasked = prodAll;
    if (!stb.wide) prodMasked[VEC_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= stb.live ? prodMasked : '0;
  end

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.live && !stb.wide) |=> (result[VEC_W-1:HALF_W] == '0));
  p_dead_slot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.live |=> (result == '0));
endmodule

// File: rtl/simd_lane_mul.sv
module simd_lane_mul
  import simd_mul_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [VEC_W-1:0]     srcA,
  input  logic [VEC_W-1:0]     srcB,
  output logic [REG_IDX_W-1:0] idxN,
  output logic [REG_IDX_W-1:0] idxM,
  output logic                 outValid,
  output logic                 wrEn,
  output logic                 undef,
  output logic [REG_IDX_W-1:0] dstIdx,
  output logic [VEC_W-1:0]     result
);
  dpStrobe_t stb;

  simd_mul_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instr(instr),
    .idxN(idxN), .idxM(idxM), .stb(stb),
    .outValid(outValid), .wrEn(wrEn), .undef(undef), .dstIdx(dstIdx)
  );

  simd_mul_dp i_dp (
    .clk(clk), .rst_n(rst_n), .opLoad(inValid),
    .srcA(srcA), .srcB(srcB), .stb(stb), .result(result)
  );
endmodule

// File: tb/test_simd_lane_mul.sv
module test_simd_lane_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [127:0] srcA = '0, srcB = '0;
  logic [4:0] idxN, idxM, dstIdx;
  logic outValid, wrEn, undef;
  logic [127:0] result;

  int nChecks = 0;
  int nFails = 0;

  logic pV[2];
  logic pU[2];
  logic [4:0] pD[2];
  logic [127:0] pR[2];
  string pT[2];

  always #10 clk = ~clk;

  simd_lane_mul i_simd_lane_mul (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instr(instr),
    .srcA(srcA), .srcB(srcB), .idxN(idxN), .idxM(idxM),
    .outValid(outValid), .wrEn(wrEn), .undef(undef), .dstIdx(dstIdx), .result(result)
  );

  function automatic logic [127:0] model(input logic [31:0] w, input logic [127:0] a,
                                         input logic [127:0] b, output logic und);
    logic isVec, isEl, poly;
    logic [1:0] sz;
    int esz, n, idx;
    logic [31:0] msk, x, y;
    logic [63:0] p;
    logic [127:0] r;
    sz = w[23:22];
    isVec = !w[31] && w[28:24] == 5'b01110 && w[21] && w[15:11] == 5'b10011 && w[10];
    isEl = !w[31] && !w[29] && w[28:24] == 5'b01111 && w[15:12] == 4'b1000 && !w[10];
    poly = isVec && w[29];
    und = !((isVec && (poly ? sz == 2'b00 : sz != 2'b11)) || (isEl && (sz == 2'b01 || sz == 2'b10)));
    r = '0;
    if (und) return r;
    esz = 8 << sz;
    n = (w[30] ? 128 : 64) / esz;
    msk = (esz == 32) ? 32'hFFFF_FFFF : ((32'd1 << esz) - 32'd1);
    idx = (sz == 2'b01) ? int'({w[11], w[21], w[20]}) : int'({w[11], w[21]});
    for (int e = 0; e < n; e++) begin
      x = 32'(a >> (e * esz)) & msk;
      y = isEl ? (32'(b >> (idx * esz)) & msk) : (32'(b >> (e * esz)) & msk);
      if (poly) begin
        p = '0;
        for (int i = 0; i < 32; i++) if (y[i]) p = p ^ (64'(x) << i);
      end else begin
        p = 64'(x) * 64'(y);
      end
      r = r | (128'(p[31:0] & msk) << (e * esz));
    end
    return r;
  endfunction

  function automatic logic [4:0] expIdxM(input logic [31:0] w);
    logic isEl;
    isEl = !w[31] && !w[29] && w[28:24] == 5'b01111 && w[15:12] == 4'b1000 && !w[10];
    return (isEl && w[23:22] == 2'b01) ? {1'b0, w[19:16]} : w[20:16];
  endfunction

  task automatic step(input logic v, input logic [31:0] w, input logic [127:0] a,
                      input logic [127:0] b, input string tag);
    logic u;
    logic [127:0] r;
    if (pV[1] || outValid) begin
      nChecks++;
      if (outValid !== pV[1] ||
          (pV[1] && (undef !== pU[1] || wrEn !== !pU[1] || dstIdx !== pD[1] || result !== pR[1]))) begin
        nFails++;
        $display("FAIL %s R1: valid=%0b undef=%0b wr=%0b dst=%0d res=%h expected valid=%0b undef=%0b wr=%0b dst=%0d res=%h",
                 pT[1], outValid, undef, wrEn, dstIdx, result, pV[1], pU[1], !pU[1], pD[1], pR[1]);
      end
    end
    r = model(w, a, b, u);
    pV[1] = pV[0]; pU[1] = pU[0]; pD[1] = pD[0]; pR[1] = pR[0]; pT[1] = pT[0];
    pV[0] = v; pU[0] = u; pD[0] = w[4:0]; pR[0] = r; pT[0] = tag;
    inValid = v; instr = w; srcA = a; srcB = b;
    #1;
    if (v) begin
      nChecks++;
      if (idxN !== w[9:5] || idxM !== expIdxM(w)) begin
        nFails++;
        $display("FAIL %s R8: idxN=%0d idxM=%0d expected %0d %0d", tag, idxN, idxM, w[9:5], expIdxM(w));
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] vecWord(input logic q, input logic p, input logic [1:0] sz,
                                          input logic [4:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    return {1'b0, q, p, 5'b01110, sz, 1'b1, rm, 5'b10011, 1'b1, rn, rd};
  endfunction

  function automatic logic [31:0] elemWord(input logic q, input logic [1:0] sz, input logic l,
                                           input logic m, input logic [3:0] rm, input logic h,
                                           input logic [4:0] rn, input logic [4:0] rd);
    return {1'b0, q, 1'b0, 5'b01111, sz, l, m, rm, 4'b1000, h, 1'b0, rn, rd};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog R1: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [1:0] sz;
    string tag;
    void'($urandom(32'h5eed_0c0d));
    for (int i = 0; i < 2; i++) begin pV[i] = 0; pU[i] = 0; pD[i] = '0; pR[i] = '0; pT[i] = ""; end
    repeat (3) @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || wrEn !== 1'b0 || undef !== 1'b0 || result !== '0) begin
      nFails++;
      $display("FAIL R9: valid=%0b wr=%0b undef=%0b res=%h expected 0 0 0 0", outValid, wrEn, undef, result);
    end
    rst_n = 1'b1;
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || wrEn !== 1'b0 || undef !== 1'b0) begin
      nFails++;
      $display("FAIL R9: after release valid=%0b wr=%0b undef=%0b expected 0 0 0", outValid, wrEn, undef);
    end

    // Directed corners
    step(1, vecWord(1, 0, 2'b00, 5'd2, 5'd1, 5'd3), {128{1'b1}}, {128{1'b1}}, "R2 wrap8");
    step(1, vecWord(1, 0, 2'b01, 5'd4, 5'd5, 5'd6), rnd128(), rnd128(), "R2 lane16");
    step(1, vecWord(1, 0, 2'b10, 5'd7, 5'd8, 5'd9), {128{1'b1}}, rnd128(), "R2 lane32");
    step(1, vecWord(0, 0, 2'b01, 5'd1, 5'd2, 5'd30), rnd128(), rnd128(), "R3 narrow");
    step(1, vecWord(0, 0, 2'b10, 5'd1, 5'd2, 5'd31), {128{1'b1}}, {128{1'b1}}, "R3 narrow32");
    step(1, vecWord(1, 1, 2'b00, 5'd3, 5'd3, 5'd3), {16{8'h03}}, {16{8'h03}}, "R6 clmul");
    step(1, vecWord(1, 1, 2'b00, 5'd3, 5'd3, 5'd3), {16{8'hFF}}, {16{8'h81}}, "R6 clmul ff");
    step(1, elemWord(1, 2'b01, 1, 1, 4'hF, 1, 5'd9, 5'd10), rnd128(), rnd128(), "R4 idx7");
    step(1, elemWord(1, 2'b01, 0, 0, 4'h2, 0, 5'd9, 5'd10), rnd128(), rnd128(), "R4 idx0");
    step(1, elemWord(1, 2'b10, 1, 1, 4'h5, 1, 5'd11, 5'd12), rnd128(), rnd128(), "R5 idx3");
    step(1, elemWord(0, 2'b10, 0, 1, 4'h0, 1, 5'd11, 5'd12), rnd128(), rnd128(), "R5 idx2 narrow");
    step(1, elemWord(1, 2'b00, 1, 0, 4'h1, 0, 5'd1, 5'd2), rnd128(), rnd128(), "R7 elem size0");
    step(1, vecWord(1, 0, 2'b11, 5'd1, 5'd2, 5'd3), rnd128(), rnd128(), "R7 size3");
    step(1, vecWord(1, 1, 2'b01, 5'd1, 5'd2, 5'd3), rnd128(), rnd128(), "R7 poly16");
    step(1, 32'h0000_0000, rnd128(), rnd128(), "R7 garbage");
    step(0, '0, '0, '0, "R1 idle");
    step(1, vecWord(1, 0, 2'b00, 5'd2, 5'd1, 5'd3), rnd128(), rnd128(), "R1 after gap");
    step(0, '0, '0, '0, "R1 idle");

    // Seeded random mixed stream
    for (int t = 0; t < 3000; t++) begin
      sz = 2'($urandom);
      case ($urandom % 5)
        0, 1: begin
          w = vecWord(1'($urandom), 0, sz, 5'($urandom), 5'($urandom), 5'($urandom));
          tag = (sz == 2'b11) ? "R7 rnd" : "R2 rnd";
        end
        2: begin
          if ($urandom % 3 != 0) sz = 2'b00;
          w = vecWord(1'($urandom), 1, sz, 5'($urandom), 5'($urandom), 5'($urandom));
          tag = (sz == 2'b00) ? "R6 rnd" : "R7 rnd";
        end
        3: begin
          w = elemWord(1'($urandom), sz, 1'($urandom), 1'($urandom), 4'($urandom),
                       1'($urandom), 5'($urandom), 5'($urandom));
          tag = (sz == 2'b01) ? "R4 rnd" : (sz == 2'b10) ? "R5 rnd" : "R7 rnd";
        end
        default: begin
          w = $urandom;
          tag = "R7 junk";
        end
      endcase
      step(($urandom % 8) != 0, w, rnd128(), rnd128(), tag);
    end
    step(0, '0, '0, '0, "R1 flush");
    step(0, '0, '0, '0, "R1 flush");
    step(0, '0, '0, '0, "R1 flush");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule